// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small fully associative cache of 4 KiB page translations for an I/O memory management unit. Every line holds a virtual page number (VA[31:12]), the address-space identifier it belongs to, a physical frame number and a permission field. A lookup presents an identifier and a virtual page number. One cycle later it returns a response strobe with hit, frame and permissions. After a miss, the external table walker installs the translation through the fill port.

Software keeps the cache coherent with a 32-bit invalidate command. The command selects which lines to drop by virtual-address granularity: every line, a 4 MiB region, or a 16 KiB region. It can also restrict the drop to one address space. Where the identifier field sits in the command depends on whether the block is built for 128 or for 4 identifiers. A configuration word sets how many lines are in use, whether lookups may continue while a miss is outstanding, and whether replacement uses a rotating pointer or the first free line.

Top module: `asid_tlb`

## Requirements
- R1: After reset every line is invalid, `lk_resp_o` and `lk_hit_o` are 0 and `lk_ready_o` is 1. The first lookup misses.
- R2: An accepted lookup (`lk_valid_i && lk_ready_o`) gives `lk_resp_o`=1 in the next cycle. `lk_hit_o` is 1 only if some active valid line has an equal identifier and VPN, and then frame and permissions are that line's. On a miss, frame and permissions read 0.
- R3: A command whose mode bits [1:0] are 0 and whose bit 31 is 0 invalidates every line.
- R4: Mode 2 (section) invalidates lines whose VPN[19:10] equals command bits [19:10].
- R5: Mode 3 (group) invalidates lines whose VPN[19:2] equals command bits [19:2]. Mode 1 invalidates nothing.
- R6: With command bit 31 set, only lines whose identifier equals the command's identifier field are invalidated. The field is bits [30:24] when built for 128 identifiers and bits [30:29] when built for 4. With bit 31 clear, the field is ignored.
- R7: A lookup in the same cycle as an invalidate sees the state after the invalidate.
- R8: `cfg_i[CNT_W-1:0]` gives the active line count, and values above LINES act as LINES. Lines at or above the count never hit and are never filled. With a count of 0, fills are dropped.
- R9: With `cfg_i[28]`=0, a fill goes to the lowest-index invalid active line, or to line 0 when none is free.
- R10: With `cfg_i[28]`=1, a fill goes to a rotating pointer. The pointer starts at 0, advances by one per fill and wraps at the active count, whatever the valid bits are.
- R11: With `cfg_i[29]`=0, a missing lookup drops `lk_ready_o` until the next fill, and lookups offered meanwhile get no response. With `cfg_i[29]`=1, `lk_ready_o` stays 1.
- R12: A fill in the same cycle as an invalidate is applied after it, so the new line stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 32 | Active count [CNT_W-1:0], rotating replacement [28], lookup during miss [29] |
| lk_valid_i | input | 1 | Lookup request |
| lk_asid_i | input | ASID_W | Lookup identifier |
| lk_vpn_i | input | 20 | Lookup VA[31:12] |
| lk_ready_o | output | 1 | Lookup accepted when high |
| lk_resp_o | output | 1 | Response strobe, one cycle after acceptance |
| lk_hit_o | output | 1 | Response hit |
| lk_pfn_o | output | PFN_W | Response frame number |
| lk_perm_o | output | PERM_W | Response permissions |
| fill_valid_i | input | 1 | Install a translation |
| fill_asid_i | input | ASID_W | Fill identifier |
| fill_vpn_i | input | 20 | Fill VA[31:12] |
| fill_pfn_i | input | PFN_W | Fill frame number |
| fill_perm_i | input | PERM_W | Fill permissions |
| flush_valid_i | input | 1 | Invalidate command strobe |
| flush_cmd_i | input | 32 | Invalidate command |

## Verification
Two collisions are provoked. In the first, an invalidate and a lookup of a cached page arrive in the same cycle. With a non-matching identifier filter the lookup must still hit. With an all-lines command it must miss, because the lookup is judged against the state after the invalidate. In the second, a fill and an all-lines invalidate arrive together: the new line must hit afterwards while an older line misses. All responses are judged by a scoreboard that queues the expected hit, frame and permissions when each lookup is driven.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VPN_W        = 20;
  localparam int CFG_HUM_BIT  = 29;
  localparam int CFG_RR_BIT   = 28;
  localparam int FL_ASID_BIT  = 31;

  typedef enum logic [1:0] {
    VM_ALL     = 2'd0,
    VM_NONE    = 2'd1,
    VM_SECTION = 2'd2,
    VM_GROUP   = 2'd3
  } va_match_e;
endpackage

// File: rtl/tlb_flush_match.sv
module tlb_flush_match import tlb_pkg::*; #(
  parameter int ASID_W = 7
) (
  input  logic [31:0]       cmd_i,
  input  logic [ASID_W-1:0] cmd_asid_i,
  input  logic [ASID_W-1:0] line_asid_i,
  input  logic [VPN_W-1:0]  line_vpn_i,
  output logic              match_o
);
  va_match_e mode;
  logic va_hit, asid_ok;

  assign mode = va_match_e'(cmd_i[1:0]);

  always_comb begin
    unique case (mode)
      VM_ALL:     va_hit = 1'b1;
      VM_SECTION: va_hit = (line_vpn_i[19:10] == cmd_i[19:10]);
      VM_GROUP:   va_hit = (line_vpn_i[19:2] == cmd_i[19:2]);
      default:    va_hit = 1'b0;
    endcase
  end

  assign asid_ok = !cmd_i[FL_ASID_BIT] || (line_asid_i == cmd_asid_i);
  assign match_o = va_hit && asid_ok;
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int LINES = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input  logic [LINES-1:0] valid_i,
  input  logic [LINES-1:0] en_i,
  input  logic             rr_en_i,
  input  logic [IDX_W-1:0] rr_ptr_i,
  input  logic [CNT_W-1:0] active_i,
  output logic [IDX_W-1:0] victim_o
);
  logic [IDX_W-1:0] first_free;
  logic [IDX_W-1:0] rr_pick;

  always_comb begin
    first_free = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (en_i[i] && !valid_i[i]) first_free = IDX_W'(i);
    end
  end

  assign rr_pick  = (CNT_W'(rr_ptr_i) < active_i) ? rr_ptr_i : '0;
  assign victim_o = rr_en_i ? rr_pick : first_free;
endmodule

// File: rtl/tlb_hit_mux.sv
module tlb_hit_mux #(
  parameter int LINES  = 8,
  parameter int PFN_W  = 20,
  parameter int PERM_W = 3
) (
  input  logic [LINES-1:0]  sel_i,
  input  logic [PFN_W-1:0]  pfn_i  [LINES],
  input  logic [PERM_W-1:0] perm_i [LINES],
  output logic [PFN_W-1:0]  pfn_o,
  output logic [PERM_W-1:0] perm_o
);
  always_comb begin
    pfn_o  = '0;
    perm_o = '0;
    for (int i = 0; i < LINES; i++) begin
      if (sel_i[i]) begin
        pfn_o  = pfn_o  | pfn_i[i];
        perm_o = perm_o | perm_i[i];
      end
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb import tlb_pkg::*; #(
  parameter int LINES     = 8,
  parameter int NUM_ASIDS = 128,
  parameter int PFN_W     = 20,
  parameter int PERM_W    = 3,
  localparam int ASID_W   = (NUM_ASIDS <= 4) ? 2 : 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       cfg_i,
  input  logic              lk_valid_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  output logic              lk_ready_o,
  output logic              lk_resp_o,
  output logic              lk_hit_o,
  output logic [PFN_W-1:0]  lk_pfn_o,
  output logic [PERM_W-1:0] lk_perm_o,
  input  logic              fill_valid_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic [PERM_W-1:0] fill_perm_i,
  input  logic              flush_valid_i,
  input  logic [31:0]       flush_cmd_i
);
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int CNT_W = $clog2(LINES + 1);

  logic [LINES-1:0]  valid_q, valid_eff, valid_nxt;
  logic [ASID_W-1:0] asid_q [LINES];
  logic [VPN_W-1:0]  vpn_q  [LINES];
  logic [PFN_W-1:0]  pfn_q  [LINES];
  logic [PERM_W-1:0] perm_q [LINES];

  logic [LINES-1:0]  kill, hit_vec, line_en;
  logic [ASID_W-1:0] cmd_asid;
  logic [CNT_W-1:0]  cnt_raw, active, vic_inc;
  logic [IDX_W-1:0]  victim, rr_q;
  logic [PFN_W-1:0]  mux_pfn;
  logic [PERM_W-1:0] mux_perm;
  logic              pending_q, accept, any_hit, fill_ok, rr_en;

  // identifier field position depends on the configured identifier count
  if (ASID_W == 2) begin : g_asid_narrow
    assign cmd_asid = flush_cmd_i[30:29];
  end else begin : g_asid_wide
    assign cmd_asid = flush_cmd_i[30:24];
  end

  assign cnt_raw = cfg_i[CNT_W-1:0];
  assign active  = (cnt_raw > CNT_W'(LINES)) ? CNT_W'(LINES) : cnt_raw;
  assign rr_en   = cfg_i[CFG_RR_BIT];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic fl_hit;
    tlb_flush_match #(.ASID_W(ASID_W)) u_fmatch (
      .cmd_i       (flush_cmd_i),
      .cmd_asid_i  (cmd_asid),
      .line_asid_i (asid_q[i]),
      .line_vpn_i  (vpn_q[i]),
      .match_o     (fl_hit)
    );
    assign line_en[i]   = (CNT_W'(i) < active);
    assign kill[i]      = flush_valid_i && fl_hit;
    assign valid_eff[i] = valid_q[i] && !kill[i];
    assign hit_vec[i]   = valid_eff[i] && line_en[i] &&
                          (asid_q[i] == lk_asid_i) && (vpn_q[i] == lk_vpn_i);
  end

  tlb_hit_mux #(.LINES(LINES), .PFN_W(PFN_W), .PERM_W(PERM_W)) u_mux (
    .sel_i  (hit_vec),
    .pfn_i  (pfn_q),
    .perm_i (perm_q),
    .pfn_o  (mux_pfn),
    .perm_o (mux_perm)
  );

  tlb_victim_sel #(.LINES(LINES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_victim (
    .valid_i  (valid_eff),
    .en_i     (line_en),
    .rr_en_i  (rr_en),
    .rr_ptr_i (rr_q),
    .active_i (active),
    .victim_o (victim)
  );

  assign lk_ready_o = !pending_q || cfg_i[CFG_HUM_BIT];
  assign accept     = lk_valid_i && lk_ready_o;
  assign any_hit    = |hit_vec;
  assign fill_ok    = fill_valid_i && (active != '0);
  assign vic_inc    = CNT_W'(victim) + CNT_W'(1);
  assign valid_nxt  = valid_eff | (fill_ok ? (LINES'(1) << victim) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < LINES; i++) begin
        asid_q[i] <= '0;
        vpn_q[i]  <= '0;
        pfn_q[i]  <= '0;
        perm_q[i] <= '0;
      end
    end else begin
      valid_q <= valid_nxt;
      for (int i = 0; i < LINES; i++) begin
        if (fill_ok && victim == IDX_W'(i)) begin
          asid_q[i] <= fill_asid_i;
          vpn_q[i]  <= fill_vpn_i;
          pfn_q[i]  <= fill_pfn_i;
          perm_q[i] <= fill_perm_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (fill_ok && rr_en) begin
      rr_q <= (vic_inc >= active) ? '0 : vic_inc[IDX_W-1:0];
    end
  end

  // a miss raised in the same cycle as a fill stays outstanding
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
    end else if (accept && !any_hit) begin
      pending_q <= 1'b1;
    end else if (fill_valid_i) begin
      pending_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_resp_o <= 1'b0;
      lk_hit_o  <= 1'b0;
      lk_pfn_o  <= '0;
      lk_perm_o <= '0;
    end else begin
      lk_resp_o <= accept;
      lk_hit_o  <= accept && any_hit;
      lk_pfn_o  <= (accept && any_hit) ? mux_pfn  : '0;
      lk_perm_o <= (accept && any_hit) ? mux_perm : '0;
    end
  end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk import tlb_pkg::*; #(
  parameter int LINES     = 8,
  parameter int NUM_ASIDS = 128,
  parameter int PFN_W     = 20,
  parameter int PERM_W    = 3,
  localparam int ASID_W   = (NUM_ASIDS <= 4) ? 2 : 7,
  localparam int CNT_W    = $clog2(LINES + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [31:0]       cfg_i,
  input logic              lk_valid_i,
  input logic              lk_ready_o,
  input logic              lk_resp_o,
  input logic              lk_hit_o,
  input logic [PFN_W-1:0]  lk_pfn_o,
  input logic [PERM_W-1:0] lk_perm_o,
  input logic              fill_valid_i,
  input logic              flush_valid_i,
  input logic [31:0]       flush_cmd_i
);
  p_resp_after_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && lk_ready_o) |=> lk_resp_o);

  p_no_resp_unaccepted_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lk_valid_i && lk_ready_o) |=> !lk_resp_o);

  p_miss_zero_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_resp_o && !lk_hit_o) |-> (lk_pfn_o == '0 && lk_perm_o == '0));

  p_empty_after_flush_all_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_resp_o && $past(flush_valid_i && flush_cmd_i == 32'h0 && !fill_valid_i, 2)
     && $past(!fill_valid_i)) |-> !lk_hit_o);

  p_same_cycle_flush_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_valid_i && flush_cmd_i == 32'h0 && lk_valid_i && lk_ready_o) |=> !lk_hit_o);

  p_zero_lines_miss_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && lk_ready_o && cfg_i[CNT_W-1:0] == '0) |=> !lk_hit_o);

  p_ready_hum_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i[CFG_HUM_BIT] |-> lk_ready_o);

  p_stall_after_miss_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_resp_o && !lk_hit_o && !cfg_i[CFG_HUM_BIT]) |-> !lk_ready_o);
endmodule

bind asid_tlb asid_tlb_chk #(
  .LINES(LINES), .NUM_ASIDS(NUM_ASIDS), .PFN_W(PFN_W), .PERM_W(PERM_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_i         (cfg_i),
  .lk_valid_i    (lk_valid_i),
  .lk_ready_o    (lk_ready_o),
  .lk_resp_o     (lk_resp_o),
  .lk_hit_o      (lk_hit_o),
  .lk_pfn_o      (lk_pfn_o),
  .lk_perm_o     (lk_perm_o),
  .fill_valid_i  (fill_valid_i),
  .flush_valid_i (flush_valid_i),
  .flush_cmd_i   (flush_cmd_i)
);

// File: tb/tb_asid_tlb.sv
`timescale 1ns/1ps
module tb_asid_tlb;
  localparam logic [31:0] HUM = 32'h2000_0000;
  localparam logic [31:0] RR  = 32'h1000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] cfg;
  logic        lk_valid, lk_ready, lk_resp, lk_hit;
  logic [6:0]  lk_asid;
  logic [19:0] lk_vpn, lk_pfn;
  logic [2:0]  lk_perm;
  logic        fl_valid;
  logic [6:0]  fl_asid;
  logic [19:0] fl_vpn, fl_pfn;
  logic [2:0]  fl_perm;
  logic        fx_valid;
  logic [31:0] fx_cmd;

  asid_tlb dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg),
    .lk_valid_i(lk_valid), .lk_asid_i(lk_asid), .lk_vpn_i(lk_vpn),
    .lk_ready_o(lk_ready), .lk_resp_o(lk_resp), .lk_hit_o(lk_hit),
    .lk_pfn_o(lk_pfn), .lk_perm_o(lk_perm),
    .fill_valid_i(fl_valid), .fill_asid_i(fl_asid), .fill_vpn_i(fl_vpn),
    .fill_pfn_i(fl_pfn), .fill_perm_i(fl_perm),
    .flush_valid_i(fx_valid), .flush_cmd_i(fx_cmd)
  );

  // 4-identifier build
  logic        d4_lk_valid, d4_ready, d4_resp, d4_hit;
  logic [1:0]  d4_lk_asid, d4_fl_asid;
  logic [19:0] d4_lk_vpn, d4_pfn, d4_fl_vpn, d4_fl_pfn;
  logic [2:0]  d4_perm;
  logic        d4_fl_valid, d4_fx_valid;
  logic [31:0] d4_fx_cmd;

  asid_tlb #(.NUM_ASIDS(4)) dut4 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(HUM | 32'd8),
    .lk_valid_i(d4_lk_valid), .lk_asid_i(d4_lk_asid), .lk_vpn_i(d4_lk_vpn),
    .lk_ready_o(d4_ready), .lk_resp_o(d4_resp), .lk_hit_o(d4_hit),
    .lk_pfn_o(d4_pfn), .lk_perm_o(d4_perm),
    .fill_valid_i(d4_fl_valid), .fill_asid_i(d4_fl_asid), .fill_vpn_i(d4_fl_vpn),
    .fill_pfn_i(d4_fl_pfn), .fill_perm_i(3'b001),
    .flush_valid_i(d4_fx_valid), .flush_cmd_i(d4_fx_cmd)
  );

  typedef struct {
    logic        hit;
    logic [19:0] pfn;
    logic [2:0]  perm;
    int          req;
  } exp_t;
  exp_t sb_q[$];

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per response
  always @(negedge clk) begin
    if (rst_n && lk_resp) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected response actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (lk_hit !== e.hit || lk_pfn !== e.pfn || lk_perm !== e.perm) begin
          errors++;
          $display("FAIL R%0d actual hit=%0b pfn=%0h perm=%0h expected hit=%0b pfn=%0h perm=%0h",
                   e.req, lk_hit, lk_pfn, lk_perm, e.hit, e.pfn, e.perm);
        end
      end
    end
  end

  task automatic look(input logic [6:0] a, input logic [19:0] v, input bit eh,
                      input logic [19:0] ep, input logic [2:0] em, input int r);
    exp_t e;
    lk_valid = 1'b1; lk_asid = a; lk_vpn = v;
    e.hit = eh; e.pfn = eh ? ep : 20'h0; e.perm = eh ? em : 3'h0; e.req = r;
    sb_q.push_back(e);
  endtask

  task automatic fill(input logic [6:0] a, input logic [19:0] v, input logic [19:0] p, input logic [2:0] m);
    fl_valid = 1'b1; fl_asid = a; fl_vpn = v; fl_pfn = p; fl_perm = m;
  endtask

  task automatic flush(input logic [31:0] c);
    fx_valid = 1'b1; fx_cmd = c;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    lk_valid = 1'b0; fl_valid = 1'b0; fx_valid = 1'b0;
    d4_lk_valid = 1'b0; d4_fl_valid = 1'b0; d4_fx_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cfg = HUM | 32'd8;
    lk_valid = 0; lk_asid = 0; lk_vpn = 0;
    fl_valid = 0; fl_asid = 0; fl_vpn = 0; fl_pfn = 0; fl_perm = 0;
    fx_valid = 0; fx_cmd = 0;
    d4_lk_valid = 0; d4_lk_asid = 0; d4_lk_vpn = 0;
    d4_fl_valid = 0; d4_fl_asid = 0; d4_fl_vpn = 0; d4_fl_pfn = 0;
    d4_fx_valid = 0; d4_fx_cmd = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk(lk_resp == 1'b0 && lk_hit == 1'b0, "R1 resp/hit", {lk_resp, lk_hit}, 0);
    chk(lk_ready == 1'b1, "R1 ready", lk_ready, 1);
    look(7'd1, 20'h12345, 0, 0, 0, 1); tick();             // R1 miss when empty

    // R2 basic hit and identifier/VPN discrimination
    fill(7'd1, 20'h12345, 20'hAAAAA, 3'b101); tick();
    look(7'd1, 20'h12345, 1, 20'hAAAAA, 3'b101, 2); tick(); // R2 hit
    look(7'd2, 20'h12345, 0, 0, 0, 2); tick();             // R2 other identifier
    look(7'd1, 20'h12346, 0, 0, 0, 2); tick();             // R2 other page
    flush(32'h0); tick();
    look(7'd1, 20'h12345, 0, 0, 0, 3); tick();             // R3 flush all

    // R9 first-free replacement
    for (int i = 0; i < 8; i++) begin
      fill(7'd3, 20'h100 + 20'(4 * i), 20'h50000 + 20'(i), 3'b111); tick();
    end
    for (int i = 0; i < 8; i++) begin
      look(7'd3, 20'h100 + 20'(4 * i), 1, 20'h50000 + 20'(i), 3'b111, 9); tick();
    end
    fill(7'd3, 20'h200, 20'h50008, 3'b111); tick();        // full: line 0
    look(7'd3, 20'h100, 0, 0, 0, 9); tick();               // R9 E0 evicted
    look(7'd3, 20'h200, 1, 20'h50008, 3'b111, 9); tick();
    flush(32'h0000_010F); tick();                          // R5 group of E3
    look(7'd3, 20'h10C, 0, 0, 0, 5); tick();
    look(7'd3, 20'h108, 1, 20'h50002, 3'b111, 5); tick();
    look(7'd3, 20'h110, 1, 20'h50004, 3'b111, 5); tick();
    fill(7'd3, 20'h300, 20'h50009, 3'b111); tick();        // R9 into line 3
    look(7'd3, 20'h300, 1, 20'h50009, 3'b111, 9); tick();
    look(7'd3, 20'h200, 1, 20'h50008, 3'b111, 9); tick();
    for (int i = 1; i < 8; i++) begin
      if (i != 3) begin
        look(7'd3, 20'h100 + 20'(4 * i), 1, 20'h50000 + 20'(i), 3'b111, 9); tick();
      end
    end

    // R4 section match, R5 reserved mode
    flush(32'h0); tick();
    fill(7'd5, 20'h00C05, 20'h1, 3'b001); tick();
    fill(7'd5, 20'h00FFF, 20'h2, 3'b010); tick();
    fill(7'd5, 20'h01000, 20'h3, 3'b011); tick();
    flush(32'h0000_0C02); tick();
    look(7'd5, 20'h00C05, 0, 0, 0, 4); tick();
    look(7'd5, 20'h00FFF, 0, 0, 0, 4); tick();
    look(7'd5, 20'h01000, 1, 20'h3, 3'b011, 4); tick();
    flush(32'h0000_1001); tick();
    look(7'd5, 20'h01000, 1, 20'h3, 3'b011, 5); tick();    // R5 mode 1 inert

    // R6 identifier-restricted flush (128 build)
    flush(32'h0); tick();
    fill(7'd5, 20'h111, 20'h11, 3'b001); tick();
    fill(7'd6, 20'h111, 20'h22, 3'b010); tick();
    flush(32'h8600_0000); tick();
    look(7'd6, 20'h111, 0, 0, 0, 6); tick();
    look(7'd5, 20'h111, 1, 20'h11, 3'b001, 6); tick();
    flush(32'h0500_0000); tick();                          // R6 field ignored
    look(7'd5, 20'h111, 0, 0, 0, 6); tick();

    // R7 lookup and flush in one cycle
    flush(32'h0); tick();
    fill(7'd1, 20'h333, 20'h33, 3'b011); tick();
    look(7'd1, 20'h333, 1, 20'h33, 3'b011, 7); tick();
    flush(32'h8900_0000); look(7'd1, 20'h333, 1, 20'h33, 3'b011, 7); tick();
    flush(32'h0); look(7'd1, 20'h333, 0, 0, 0, 7); tick();

    // R12 fill and flush in one cycle
    fill(7'd1, 20'h444, 20'h44, 3'b110); tick();
    flush(32'h0); fill(7'd2, 20'h555, 20'h55, 3'b001); tick();
    look(7'd2, 20'h555, 1, 20'h55, 3'b001, 12); tick();
    look(7'd1, 20'h444, 0, 0, 0, 12); tick();

    // R8 active line count
    flush(32'h0); tick();
    cfg = HUM | 32'd2;
    fill(7'd1, 20'h600, 20'h60, 3'b001); tick();
    fill(7'd1, 20'h601, 20'h61, 3'b001); tick();
    fill(7'd1, 20'h602, 20'h62, 3'b001); tick();           // no free: line 0
    look(7'd1, 20'h600, 0, 0, 0, 8); tick();
    look(7'd1, 20'h601, 1, 20'h61, 3'b001, 8); tick();
    look(7'd1, 20'h602, 1, 20'h62, 3'b001, 8); tick();
    cfg = HUM | 32'd0;
    look(7'd1, 20'h601, 0, 0, 0, 8); tick();
    fill(7'd1, 20'h603, 20'h63, 3'b001); tick();           // dropped
    cfg = HUM | 32'd2;
    look(7'd1, 20'h603, 0, 0, 0, 8); tick();
    look(7'd1, 20'h601, 1, 20'h61, 3'b001, 8); tick();
    cfg = HUM | 32'd15;                                    // clamps to 8
    look(7'd1, 20'h601, 1, 20'h61, 3'b001, 8); tick();

    // R10 rotating replacement over 3 lines
    flush(32'h0); tick();
    cfg = HUM | RR | 32'd3;
    fill(7'd4, 20'h700, 20'h70, 3'b010); tick();
    fill(7'd4, 20'h704, 20'h71, 3'b010); tick();
    fill(7'd4, 20'h708, 20'h72, 3'b010); tick();
    flush(32'h0000_070B); tick();                          // frees line 2
    fill(7'd4, 20'h70C, 20'h73, 3'b010); tick();           // pointer: line 0
    look(7'd4, 20'h700, 0, 0, 0, 10); tick();
    look(7'd4, 20'h704, 1, 20'h71, 3'b010, 10); tick();
    look(7'd4, 20'h70C, 1, 20'h73, 3'b010, 10); tick();
    look(7'd4, 20'h708, 0, 0, 0, 10); tick();
    fill(7'd4, 20'h710, 20'h74, 3'b010); tick();           // line 1
    look(7'd4, 20'h704, 0, 0, 0, 10); tick();
    look(7'd4, 20'h710, 1, 20'h74, 3'b010, 10); tick();
    look(7'd4, 20'h70C, 1, 20'h73, 3'b010, 10); tick();

    // R11 blocking on miss
    cfg = 32'd8;
    flush(32'h0); fill(7'd7, 20'h7FF, 20'h7F, 3'b001); tick();
    chk(lk_ready == 1'b1, "R11 ready before miss", lk_ready, 1);
    look(7'd1, 20'h800, 0, 0, 0, 11); tick();
    chk(lk_ready == 1'b0, "R11 stalled after miss", lk_ready, 0);
    lk_valid = 1'b1; lk_asid = 7'd7; lk_vpn = 20'h7FF; tick(); // ignored
    chk(lk_ready == 1'b0, "R11 still stalled", lk_ready, 0);
    fill(7'd1, 20'h800, 20'h80, 3'b100); tick();
    chk(lk_ready == 1'b1, "R11 released by fill", lk_ready, 1);
    look(7'd1, 20'h800, 1, 20'h80, 3'b100, 11); tick();
    cfg = HUM | 32'd8;
    look(7'd1, 20'h900, 0, 0, 0, 11); tick();
    chk(lk_ready == 1'b1, "R11 hit-under-miss ready", lk_ready, 1);

    // R6 identifier field at [30:29] in the 4-identifier build
    d4_fl_valid = 1'b1; d4_fl_asid = 2'd2; d4_fl_vpn = 20'h222; d4_fl_pfn = 20'h1; tick();
    d4_fl_valid = 1'b1; d4_fl_asid = 2'd1; d4_fl_vpn = 20'h222; d4_fl_pfn = 20'h2; tick();
    d4_fx_valid = 1'b1; d4_fx_cmd = 32'hC000_0000; tick();
    d4_lk_valid = 1'b1; d4_lk_asid = 2'd2; d4_lk_vpn = 20'h222; tick();
    @(negedge clk);
    chk(d4_resp && !d4_hit, "R6 narrow flushed", {d4_resp, d4_hit}, 2'b10);
    d4_lk_valid = 1'b1; d4_lk_asid = 2'd1; d4_lk_vpn = 20'h222; tick();
    @(negedge clk);
    chk(d4_resp && d4_hit && d4_pfn == 20'h2, "R6 narrow kept", {d4_resp, d4_hit, d4_pfn}, {2'b11, 20'h2});

    tick();
    @(negedge clk);
    chk(sb_q.size() == 0, "R2 all responses seen", sb_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule